// File: doc/BRIEF.md
# Parallel Neuron Layer Engine

This block computes one layer of a feed-forward network with sixteen neuron slots that all work at once. After the input count, the active neuron count, the input precision and the activation table have been written, a start strobe opens a neuron cycle. The block then steps a shared address counter through the inputs, one per clock. At each step it takes one input word and one row of sixteen weights from memories outside the block, and every neuron adds its own product to a signed 32-bit accumulator.

In the final cycle each sum is clipped to 16 bits. The clipped value either goes straight to the result, or passes through a programmable sixteen-segment piecewise-linear activation. The result is then latched into the neuron's output register, unless freeze is held. An indexed, output-enabled port reads the sixteen output registers.

Cycle length depends only on the number of inputs, never on how many neurons are active.

Top module: `nnl_layer_engine`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears busy, the address counter, all accumulators and all output registers. It restores the configuration to input count 0, neuron count 16, 16-bit precision and bypass on.
- R2: In idle, `start` high at a rising edge opens a neuron cycle, clears every accumulator and raises `busy` for the next cycle. `start` pulses while busy have no effect on the cycle.
- R3: `busy` stays high for exactly N+1 clock cycles, where N is the programmed input count (one cycle when N is 0), whatever the active neuron count.
- R4: During step k (k = 0..N-1) the block reads input `in_data` and, for neuron n, weight `wt_data[16n+15:16n]` while `wt_addr` equals k. Neuron n accumulates the signed sum of input times weight with 32-bit two's-complement wrap.
- R5: `wt_addr` is 0 in the first step of a cycle and rises by one in each following step.
- R6: The precision code (mode register bits [1:0]) selects the input value. Code 0 is `in_data[0]` as unsigned 0 or 1. Code 1 is `in_data[3:0]` signed. Code 2 is `in_data[7:0]` signed. Code 3 is all 16 bits signed.
- R7: When `freeze` is high in the final cycle, all output registers keep their previous values; otherwise they load the new results.
- R8: Configuration writes go through `cfg_we`/`cfg_sel`/`cfg_idx`/`cfg_wdata`. Select 0 is the input count, 1 the neuron count, and 2 the mode (bit 2 = bypass). Selects 3, 4 and 5 are the breakpoint, the slope (signed, 8 fraction bits) and the offset of segment `cfg_idx`. Writes while busy are ignored.
- R9: `out_data` shows output register `out_sel` while `out_oe` is high and is 0 while it is low.
- R10: Output registers whose index is at or above the programmed neuron count are 0 after a cycle.
- R11: The accumulator saturates to the 16-bit range; with bypass on, the result is that saturated value.
- R12: With bypass off, the segment is the highest index i whose breakpoint is at most the saturated sum s (segment 0 if none); breakpoints are assumed ascending. The result is saturate16(((slope_i * s) >>> 8) + offset_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_idx | input | 4 | Activation segment index |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Start strobe for a neuron cycle |
| freeze | input | 1 | Hold output registers at cycle end |
| busy | output | 1 | Neuron cycle in progress |
| wt_addr | output | 8 | Step address for weight and input memories |
| wt_data | input | 256 | Sixteen 16-bit signed weights at `wt_addr` |
| in_data | input | 16 | Input word at `wt_addr` |
| out_sel | input | 4 | Output register index |
| out_oe | input | 1 | Output enable |
| out_data | output | 16 | Selected neuron result |

## Verification
The main function is first swept with bypass on over every input count from 0 to 8, using weights that differ by neuron and by step. A wrong address order or a missed step therefore shows up as a wrong sum in specific neurons. Inputs carry junk upper bits so that each precision code is told apart by which bits reach the sum. Large same-sign products drive both saturation rails.

The activation is exercised with sums placed exactly on and one below each breakpoint, which separates off-by-one segment choices. Further runs move the neuron count, hold freeze, and write configuration or start in the middle of a cycle. These runs show that only the intended registers move and that the busy length follows the input count alone.

// File: rtl/nnl_pkg.sv
// Package: shared widths, encodings and arithmetic helpers for the layer engine.
// Assumes 16-bit data and 32-bit accumulators throughout.
package nnl_pkg;

    localparam int DW    = 16;
    localparam int ACC_W = 32;

    typedef enum logic [1:0] {
        PREC_1  = 2'd0,
        PREC_4  = 2'd1,
        PREC_8  = 2'd2,
        PREC_16 = 2'd3
    } prec_e;

    typedef enum logic [2:0] {
        CFG_NIN   = 3'd0,
        CFG_NNEU  = 3'd1,
        CFG_MODE  = 3'd2,
        CFG_BP    = 3'd3,
        CFG_SLOPE = 3'd4,
        CFG_OFS   = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_ACT  = 2'd2
    } state_e;

    // Clip a wide signed value into the 16-bit signed range.
    function automatic logic signed [DW-1:0] sat_dw(input logic signed [ACC_W-1:0] v);
        if (v > ACC_W'(32767))
            return 16'sh7fff;
        else if (v < -ACC_W'(32768))
            return 16'sh8000;
        else
            return v[DW-1:0];
    endfunction

    // Extract the input value at the chosen precision, sign-extended to 16 bits.
    function automatic logic signed [DW-1:0] widen_in(input logic [DW-1:0] d, input prec_e p);
        case (p)
            PREC_1:  return {{(DW-1){1'b0}}, d[0]};
            PREC_4:  return {{(DW-4){d[3]}}, d[3:0]};
            PREC_8:  return {{(DW-8){d[7]}}, d[7:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/nnl_addr_ctr.sv
// Module: step address counter shared by the weight and input memories.
// Clear has priority over count enable; the counter wraps at its width.
module nnl_addr_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    // Clear to zero at cycle start, advance once per accumulation step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/nnl_neuron.sv
// Module: one multiply-accumulate neuron slot.
// Assumes signed 16-bit input and weight; the 32-bit sum wraps on overflow.
module nnl_neuron
    import nnl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [DW-1:0]    x,
    input  logic signed [DW-1:0]    w,
    output logic signed [ACC_W-1:0] acc
);

    // Reset or clear the sum, else add one product per enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (en)
            acc <= acc + x * w;
    end

    // R2
    acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

endmodule

// File: rtl/nnl_pwl.sv
// Module: piecewise-linear activation with optional bypass (combinational).
// Assumes breakpoints are stored in ascending order; slope has 8 fraction bits.
module nnl_pwl
    import nnl_pkg::*;
#(
    parameter int N_SEG = 16,
    localparam int SEG_W = $clog2(N_SEG)
) (
    input  logic signed [DW-1:0]         s,
    input  logic                         bypass,
    input  logic [N_SEG-1:0][DW-1:0]     bp,
    input  logic [N_SEG-1:0][DW-1:0]     slope,
    input  logic [N_SEG-1:0][DW-1:0]     ofs,
    output logic signed [DW-1:0]         y
);

    logic [SEG_W:0]            n_ge;
    logic [SEG_W-1:0]          seg;
    logic signed [ACC_W-1:0]   prod;
    logic signed [ACC_W-1:0]   lin;

    // Count breakpoints not above the input to find the active segment.
    always_comb begin
        n_ge = '0;
        for (int i = 0; i < N_SEG; i++)
            if (s >= $signed(bp[i]))
                n_ge = n_ge + 1'b1;
        seg = (n_ge == '0) ? '0 : SEG_W'(n_ge - 1'b1);
    end

    // Apply the chosen segment's line, then clip, or pass the input through.
    always_comb begin
        prod = $signed(slope[seg]) * s;
        lin  = (prod >>> 8) + ACC_W'($signed(ofs[seg]));
        y    = bypass ? s : sat_dw(lin);
    end

endmodule

// File: rtl/nnl_layer_engine.sv
// Module: sixteen-slot parallel neuron layer with sequencer, configuration,
// activation and indexed read port. Assumes the weight and input memories
// return data combinationally for the address on wt_addr.
module nnl_layer_engine
    import nnl_pkg::*;
#(
    parameter int N_NEU  = 16,
    parameter int ADDR_W = 8,
    parameter int N_SEG  = 16,
    localparam int IDX_W = $clog2(N_NEU),
    localparam int SEG_W = $clog2(N_SEG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [SEG_W-1:0]      cfg_idx,
    input  logic [DW-1:0]         cfg_wdata,
    input  logic                  start,
    input  logic                  freeze,
    output logic                  busy,
    output logic [ADDR_W-1:0]     wt_addr,
    input  logic [N_NEU*DW-1:0]   wt_data,
    input  logic [DW-1:0]         in_data,
    input  logic [IDX_W-1:0]      out_sel,
    input  logic                  out_oe,
    output logic [DW-1:0]         out_data
);

    state_e                    st;
    logic [ADDR_W-1:0]         n_in_q;
    logic [IDX_W:0]            n_neu_q;
    prec_e                     prec_q;
    logic                      byp_q;
    logic [N_SEG-1:0][DW-1:0]  bp_q;
    logic [N_SEG-1:0][DW-1:0]  slope_q;
    logic [N_SEG-1:0][DW-1:0]  ofs_q;
    logic [N_NEU-1:0][DW-1:0]  out_q;
    logic                      step_clr;
    logic                      step_en;
    logic                      last_step;
    logic signed [DW-1:0]      x_ext;

    assign busy      = (st != ST_IDLE);
    assign step_clr  = (st == ST_IDLE) && start;
    assign step_en   = (st == ST_ACC);
    assign last_step = (wt_addr == n_in_q - ADDR_W'(1));
    assign x_ext     = widen_in(in_data, prec_q);

    // Sequencer: idle -> accumulate N steps -> one activation/latch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else begin
            case (st)
                ST_IDLE: if (start) st <= (n_in_q == '0) ? ST_ACT : ST_ACC;
                ST_ACC:  if (last_step) st <= ST_ACT;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Configuration registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_in_q  <= '0;
            n_neu_q <= (IDX_W+1)'(N_NEU);
            prec_q  <= PREC_16;
            byp_q   <= 1'b1;
            bp_q    <= '0;
            slope_q <= '0;
            ofs_q   <= '0;
        end else if (cfg_we && (st == ST_IDLE)) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_NIN:   n_in_q         <= cfg_wdata[ADDR_W-1:0];
                CFG_NNEU:  n_neu_q        <= cfg_wdata[IDX_W:0];
                CFG_MODE: begin
                    prec_q <= prec_e'(cfg_wdata[1:0]);
                    byp_q  <= cfg_wdata[2];
                end
                CFG_BP:    bp_q[cfg_idx]    <= cfg_wdata;
                CFG_SLOPE: slope_q[cfg_idx] <= cfg_wdata;
                CFG_OFS:   ofs_q[cfg_idx]   <= cfg_wdata;
                default: ;
            endcase
        end
    end

    nnl_addr_ctr #(.W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .en    (step_en),
        .cnt   (wt_addr)
    );

    for (genvar g = 0; g < N_NEU; g++) begin : g_neu
        logic signed [ACC_W-1:0] acc;
        logic signed [DW-1:0]    y;

        nnl_neuron u_neu (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (step_clr),
            .en    (step_en),
            .x     (x_ext),
            .w     (wt_data[g*DW +: DW]),
            .acc   (acc)
        );

        nnl_pwl #(.N_SEG(N_SEG)) u_pwl (
            .s      (sat_dw(acc)),
            .bypass (byp_q),
            .bp     (bp_q),
            .slope  (slope_q),
            .ofs    (ofs_q),
            .y      (y)
        );

        // Latch this slot's result at cycle end unless frozen; inactive slots read 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q[g] <= '0;
            else if ((st == ST_ACT) && !freeze)
                out_q[g] <= ((IDX_W+1)'(g) < n_neu_q) ? y : '0;
        end
    end

    // Indexed read port gated by output enable.
    assign out_data = out_oe ? out_q[out_sel] : '0;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && (wt_addr == '0) && (out_q == '0)));

    // R5
    addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wt_addr == '0));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ACC) && ($past(st) == ST_ACC)) |-> (wt_addr == $past(wt_addr) + ADDR_W'(1)));

    // R8
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(n_in_q) && $stable(n_neu_q) && $stable(bp_q)));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(out_q));

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_oe |-> (out_data == '0));

endmodule

// File: tb/nnl_layer_engine_tb.sv
module nnl_layer_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_sel = '0;
    logic [3:0]   cfg_idx = '0;
    logic [15:0]  cfg_wdata = '0;
    logic         start = 1'b0;
    logic         freeze = 1'b0;
    logic         busy;
    logic [7:0]   wt_addr;
    logic [255:0] wt_data;
    logic [15:0]  in_data;
    logic [3:0]   out_sel = '0;
    logic         out_oe = 1'b0;
    logic [15:0]  out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] wmem [0:15][0:15];
    logic [15:0] imem [0:15];
    int bp_m [0:15];
    int sl_m [0:15];
    int of_m [0:15];
    int exp_o [0:15];
    int cur_ni, cur_prec, cur_nn, cur_byp;

    always #10 clk = ~clk;

    nnl_layer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .start(start), .freeze(freeze),
        .busy(busy), .wt_addr(wt_addr), .wt_data(wt_data), .in_data(in_data),
        .out_sel(out_sel), .out_oe(out_oe), .out_data(out_data)
    );

    always_comb begin
        for (int n = 0; n < 16; n++) wt_data[n*16 +: 16] = wmem[wt_addr[3:0]][n];
        in_data = imem[wt_addr[3:0]];
    end

    task automatic chk(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int xext(logic [15:0] d, int p);
        case (p)
            0: return int'(d[0]);
            1: return int'($signed(d[3:0]));
            2: return int'($signed(d[7:0]));
            default: return int'($signed(d));
        endcase
    endfunction

    function automatic int pwl_m(int s);
        int c = 0;
        int seg;
        int t;
        for (int i = 0; i < 16; i++) if (s >= bp_m[i]) c++;
        seg = (c == 0) ? 0 : c - 1;
        t = (sl_m[seg] * s) >>> 8;
        return sat16(longint'(t + of_m[seg]));
    endfunction

    task automatic cfg_w(int sel, int idx, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_idx = 4'(idx); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(int ni, int prec, int nn, int byp);
        cfg_w(0, 0, ni); cfg_w(1, 0, nn); cfg_w(2, 0, prec | (byp << 2));
        cur_ni = ni; cur_prec = prec; cur_nn = nn; cur_byp = byp;
    endtask

    task automatic load_lut();
        for (int i = 0; i < 16; i++) begin
            bp_m[i] = -8000 + i * 1000;
            sl_m[i] = 256 - i * 24;
            of_m[i] = i * 150 - 900;
            cfg_w(3, i, bp_m[i]); cfg_w(4, i, sl_m[i]); cfg_w(5, i, of_m[i]);
        end
    endtask

    task automatic read_all(string req);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            out_sel = 4'(n); out_oe = 1'b1;
            #1 chk(req, int'($signed(out_data)), exp_o[n]);
        end
        out_oe = 1'b0;
    endtask

    // Run one neuron cycle, checking step addresses, busy length and all outputs.
    task automatic go(string req, bit frz, bit poke_start);
        int tmp [0:15];
        int cnt = 0;
        for (int n = 0; n < 16; n++) begin
            int acc = 0;
            for (int k = 0; k < cur_ni; k++)
                acc += xext(imem[k], cur_prec) * int'($signed(wmem[k][n]));
            if (n >= cur_nn) tmp[n] = 0;
            else if (cur_byp != 0) tmp[n] = sat16(longint'(acc));
            else tmp[n] = pwl_m(sat16(longint'(acc)));
        end
        @(negedge clk);
        freeze = frz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            if (cnt < cur_ni) chk("R5 step address", int'(wt_addr), cnt);
            if (poke_start && cnt == 1) start = 1'b1;
            else start = 1'b0;
            cnt++;
            @(negedge clk);
            if (cnt > 300) break;
        end
        start = 1'b0; freeze = 1'b0;
        chk("R3 busy length", cnt, cur_ni + 1);
        if (!frz) for (int n = 0; n < 16; n++) exp_o[n] = tmp[n];
        read_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            imem[k] = 16'(37 * k - 150);
            for (int n = 0; n < 16; n++) wmem[k][n] = 16'((n - 7) * (k + 2) + k);
        end
        for (int n = 0; n < 16; n++) exp_o[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 address after reset", int'(wt_addr), 0);
        read_all("R1 outputs after reset");
        cur_ni = 0; cur_prec = 3; cur_nn = 16; cur_byp = 1;
        go("R1 default config run", 1'b0, 1'b0);

        // R4 R11 bypass sweep over input counts
        for (int ni = 0; ni <= 8; ni++) begin
            setup(ni, 3, 16, 1);
            go("R4 bypass sum", 1'b0, 1'b0);
        end

        // R10 neuron count; R3 latency independent of count
        setup(4, 3, 1, 1);  go("R10 one neuron", 1'b0, 1'b0);
        setup(4, 3, 5, 1);  go("R10 five neurons", 1'b0, 1'b0);
        setup(4, 3, 16, 1); go("R10 all neurons", 1'b0, 1'b0);

        // R6 precision codes with junk upper bits
        for (int k = 0; k < 16; k++) imem[k] = 16'hC300 | 16'((k * 29 + 7) & 255);
        for (int p = 0; p < 3; p++) begin
            setup(6, p, 16, 1);
            go("R6 precision", 1'b0, 1'b0);
        end

        // R11 saturation both rails
        for (int k = 0; k < 2; k++) begin
            imem[k] = 16'd30000;
            for (int n = 0; n < 16; n++) wmem[k][n] = (n < 8) ? 16'd30000 : 16'(-30000);
        end
        setup(2, 3, 16, 1);
        go("R11 saturation", 1'b0, 1'b0);

        // R12 activation at and just below each breakpoint
        load_lut();
        imem[0] = 16'd1;
        for (int n = 0; n < 16; n++)
            wmem[0][n] = 16'((n % 2 == 0) ? bp_m[n / 2 + 4] : bp_m[n / 2 + 4] - 1);
        setup(1, 3, 16, 0);
        go("R12 breakpoint edges", 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) begin
            imem[k] = 16'(37 * k - 150);
            for (int n = 0; n < 16; n++) wmem[k][n] = 16'((n - 7) * (k + 2) * 9 + k);
        end
        setup(8, 3, 16, 0);
        go("R12 spread sums", 1'b0, 1'b0);

        // R7 freeze keeps previous outputs, then release updates them
        for (int n = 0; n < 16; n++) wmem[0][n] = 16'(n * 3 - 20);
        go("R7 frozen outputs", 1'b1, 1'b0);
        setup(8, 3, 16, 1);
        go("R7 after release", 1'b0, 1'b0);

        // R2 start pulse while busy has no effect
        setup(5, 3, 16, 1);
        go("R2 start while busy", 1'b0, 1'b1);
        @(negedge clk);
        chk("R2 idle after cycle", int'(busy), 0);

        // R8 config write while busy ignored
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'd2;
        @(negedge clk); cfg_we = 1'b0;
        while (busy) @(negedge clk);
        go("R8 input count unchanged", 1'b0, 1'b0);

        // R9 output enable low forces zero
        @(negedge clk); out_sel = 4'd3; out_oe = 1'b0;
        #1 chk("R9 oe low", int'(out_data), 0);

        // R1 reset in mid-cycle
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 busy after mid reset", int'(busy), 0);
        chk("R1 address after mid reset", int'(wt_addr), 0);
        for (int n = 0; n < 16; n++) exp_o[n] = 0;
        read_all("R1 outputs after mid reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule